// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It runs on the fast input clock and divides it by N = P*B + A. It does this by chaining three counters. A dual-modulus prescaler counts either P or P+1 input cycles per step. A swallow counter holds the modulus at P+1 for the first A prescaler steps of each output period. A main counter ends the period after B prescaler steps. At the end of each period the block emits a comparison pulse `fp`, which a phase comparator downstream compares with the reference pulse.

The base modulus P can be chosen at run time, 64 or 32, with one mode input. The swallow value A, the main value B and the mode are sampled only when a period begins. A change made in the middle of a period therefore never produces a short or stretched period. The `mod_hi` output shows the modulus selection, so a loop monitor can observe it.

Values outside the legal ranges are outside the scope of this block: A above B, B below 3, and A above 63. Reference division and phase comparison are also outside its scope.

Top module: `swallow_fb_divider`

## Requirements
- R1: While `run_en` is high, `fp` pulses every N = P*B + A input clock cycles. The first pulse comes N cycles after the first rising clock edge at which `run_en` is sampled high.
- R2: `pre_sel` = 0 selects P = 64, so prescaler steps last 64 or 65 cycles. `pre_sel` = 1 selects P = 32, so steps last 32 or 33 cycles.
- R3: In every period, `mod_hi` is high for the first A prescaler steps, which is A*(P+1) input cycles. It is low for the remaining B-A steps. It changes only at prescaler step boundaries.
- R4: With A = 0, `mod_hi` stays low for the whole period and the period is P*B cycles.
- R5: With A = B, every prescaler step lasts P+1 cycles, `mod_hi` is high for the whole period, and the period is (P+1)*B cycles.
- R6: `fp` is high for exactly one input clock cycle per period.
- R7: Changes to `swallow_a`, `main_b` or `pre_sel` during a period do not alter that period. They take effect from the next period on.
- R8: While `run_en` is low, `fp` stays low and the divider is held at the start of a period. When `run_en` is raised again, a full period of the current settings begins.
- R9: While `rst_n` is low, `fp` and `mod_hi` are low.
- R10: Full-width settings divide correctly: B = 2047 with A = 63 and P = 32 gives N = 65567.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Division runs while high; held at period start while low |
| pre_sel | input | 1 | Prescaler base: 0 selects 64, 1 selects 32 |
| swallow_a | input | 7 | Swallow count A (0 to 63) |
| main_b | input | 11 | Main count B (3 to 2047, not below A) |
| fp | output | 1 | One-cycle comparison pulse at each period end |
| mod_hi | output | 1 | Modulus control: high selects P+1 for the current prescaler step |

## Verification
The bench builds the divider with its default widths and the real base moduli of 32 and 64. Whole periods can therefore be measured against the true ratio formula, including the 65/33 stretched steps. Small B values keep most periods to a few hundred cycles, which leaves room for several mode, swallow and boundary phases. A single period with B = 2047 and A = 63 also fits within the run and exercises both counters at full width. Each setting change is made in the middle of a period, so the period in progress shows whether the new values were taken early.

// File: rtl/swd_pkg.sv
package swd_pkg;

  // Prescaler base selection, encoded as the pre_sel input bit.
  typedef enum logic {
    MODE_LARGE = 1'b0,
    MODE_SMALL = 1'b1
  } pre_mode_e;

  // Base modulus P for a given mode.
  function automatic int unsigned swd_base(pre_mode_e mode, int unsigned lg_small,
                                           int unsigned lg_large);
    return (mode == MODE_SMALL) ? (32'd1 << lg_small) : (32'd1 << lg_large);
  endfunction

  // Length of one prescaler step in input cycles: P, or P+1 while swallowing.
  function automatic int unsigned swd_step_len(pre_mode_e mode, logic swallow,
                                               int unsigned lg_small, int unsigned lg_large);
    return swd_base(mode, lg_small, lg_large) + 32'(swallow);
  endfunction

  // Whole feedback ratio N = P*B + A.
  function automatic int unsigned swd_ratio(pre_mode_e mode, int unsigned a, int unsigned b,
                                            int unsigned lg_small, int unsigned lg_large);
    return swd_base(mode, lg_small, lg_large) * b + a;
  endfunction

endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler
  import swd_pkg::*;
#(
  parameter int unsigned P_LG_SMALL = 5,
  parameter int unsigned P_LG_LARGE = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  pre_mode_e mode_in,
  input  logic      swallow,
  output logic      step_tc,
  output pre_mode_e mode_q
);
  localparam int unsigned PC_W = P_LG_LARGE + 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] term;

  // Last count of the current step: P-1, or P while the swallow counter is live.
  always_comb term = PC_W'(swd_step_len(mode_q, swallow, P_LG_SMALL, P_LG_LARGE) - 32'd1);

  assign step_tc = (pc == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      mode_q <= MODE_LARGE;
    end else if (load) begin
      pc     <= '0;
      mode_q <= mode_in;
    end else if (step_tc) begin
      pc <= '0;
    end else begin
      pc <= pc + PC_W'(1);
    end
  end
endmodule

// File: rtl/swd_swallow_ctr.sv
module swd_swallow_ctr #(
  parameter int unsigned A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [A_W-1:0] a_in,
  output logic           swallow
);
  logic [A_W-1:0] a_cnt;

  assign swallow = (a_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= '0;
    end else if (load) begin
      a_cnt <= a_in;
    end else if (step && swallow) begin
      a_cnt <= a_cnt - A_W'(1);
    end
  end
endmodule

// File: rtl/swd_main_ctr.sv
module swd_main_ctr #(
  parameter int unsigned B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [B_W-1:0] b_in,
  output logic           b_last
);
  logic [B_W-1:0] b_cnt;

  // Counts remaining prescaler steps; zero marks the final step of the period.
  assign b_last = (b_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_cnt <= '0;
    end else if (load) begin
      b_cnt <= b_in - B_W'(1);
    end else if (step) begin
      b_cnt <= b_cnt - B_W'(1);
    end
  end
endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider
  import swd_pkg::*;
#(
  parameter int unsigned A_W        = 7,
  parameter int unsigned B_W        = 11,
  parameter int unsigned P_LG_SMALL = 5,
  parameter int unsigned P_LG_LARGE = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic           pre_sel,
  input  logic [A_W-1:0] swallow_a,
  input  logic [B_W-1:0] main_b,
  output logic           fp,
  output logic           mod_hi
);
  // Named internal events, also observed by the bound checker.
  logic      primed;
  logic      hold_start;
  logic      period_end;
  logic      step_tc;
  logic      swallow;
  logic      b_last;
  logic      load;
  pre_mode_e mode_q;

  assign hold_start = !run_en || !primed;
  assign period_end = !hold_start && step_tc && b_last;
  assign load       = hold_start || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      fp     <= 1'b0;
    end else begin
      primed <= 1'b1;
      fp     <= period_end;
    end
  end

  swd_prescaler #(
    .P_LG_SMALL(P_LG_SMALL),
    .P_LG_LARGE(P_LG_LARGE)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .mode_in(pre_mode_e'(pre_sel)),
    .swallow(swallow),
    .step_tc(step_tc),
    .mode_q (mode_q)
  );

  swd_swallow_ctr #(.A_W(A_W)) u_swallow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step_tc),
    .a_in   (swallow_a),
    .swallow(swallow)
  );

  swd_main_ctr #(.B_W(B_W)) u_main (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step_tc),
    .b_in  (main_b),
    .b_last(b_last)
  );

  assign mod_hi = swallow;
endmodule

// File: rtl/swd_checker.sv
module swd_checker
  import swd_pkg::*;
#(
  parameter int unsigned P_LG_SMALL = 5,
  parameter int unsigned P_LG_LARGE = 6
) (
  input logic      clk,
  input logic      rst_n,
  input logic      run_en,
  input logic      fp,
  input logic      mod_hi,
  input logic      step_tc,
  input logic      hold_start,
  input logic      period_end,
  input pre_mode_e mode_q
);
  localparam int unsigned CW = P_LG_LARGE + 2;

  // Independent count of cycles within the current prescaler step.
  logic [CW-1:0] step_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     step_cnt <= '0;
    else if (hold_start || step_tc) step_cnt <= '0;
    else                            step_cnt <= step_cnt + CW'(1);
  end

  AST_FP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp); // R6

  AST_IDLE_NO_FP: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !fp); // R8

  AST_STEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tc && !hold_start) |-> (32'(step_cnt) + 32'd1 == swd_step_len(mode_q, mod_hi, P_LG_SMALL, P_LG_LARGE))); // R2

  AST_SWALLOW_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> $past(hold_start || period_end)); // R3

  AST_SWALLOW_FALL_AT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> $past(step_tc || hold_start)); // R3

  AST_MODE_HELD_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold_start) && !$past(period_end)) |-> $stable(mode_q)); // R7
endmodule

bind swallow_fb_divider swd_checker #(
  .P_LG_SMALL(P_LG_SMALL),
  .P_LG_LARGE(P_LG_LARGE)
) u_swd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .fp        (fp),
  .mod_hi    (mod_hi),
  .step_tc   (step_tc),
  .hold_start(hold_start),
  .period_end(period_end),
  .mode_q    (mode_q)
);

// File: tb/tb_swallow_fb_divider.sv
module tb_swallow_fb_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en;
  logic        pre_sel;
  logic [6:0]  swallow_a;
  logic [10:0] main_b;
  logic        fp;
  logic        mod_hi;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swallow_fb_divider dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .pre_sel  (pre_sel),
    .swallow_a(swallow_a),
    .main_b   (main_b),
    .fp       (fp),
    .mod_hi   (mod_hi)
  );

  typedef struct {
    int    n;
    int    hi;   // -1: swallow count not checked (period spans a setting change)
    string tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  int   idle_pulses = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: P is 64 for mode bit 0 and 32 for mode bit 1.
  function automatic int base_of(input bit pre);
    return pre ? 32 : 64;
  endfunction

  // Driver: queue the periods one setting should produce.
  task automatic push_periods(input int a, input int b, input bit pre, input int count,
                              input bit last_crosses, input string tag);
    for (int i = 0; i < count; i++) begin
      exp_t e;
      e.n   = base_of(pre) * b + a;
      e.hi  = a * (base_of(pre) + 1);
      e.tag = tag;
      if (last_crosses && i == count - 1) begin
        e.hi  = -1;
        e.tag = "R7";
      end
      sb.push_back(e);
    end
  endtask

  task automatic drive_cfg(input int a, input int b, input bit pre);
    @(posedge clk); #1;
    swallow_a = 7'(a);
    main_b    = 11'(b);
    pre_sel   = pre;
  endtask

  task automatic wait_left(input int k);
    while (sb.size() > k) @(negedge clk);
  endtask

  // Monitor: measure pulse spacing and swallow cycles, compare with the queue.
  int cnt = 0, hic = 0;
  bit en_prev = 0, fp_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fp_prev) check(!fp, "R6", "fp width", int'(fp), 0);
      if (!run_en) begin
        if (fp && !en_prev) idle_pulses++;
        cnt = 0;
        hic = 0;
      end else begin
        if (en_prev) begin
          cnt++;
          if (mod_hi) hic++;
        end
        if (fp) begin
          if (sb.size() == 0) begin
            check(0, "R1", "unexpected pulse after cycles", cnt, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(cnt == e.n, e.tag, "period", cnt, e.n);
            if (e.hi >= 0) check(hic == e.hi, {e.tag, "/R3"}, "mod_hi cycles", hic, e.hi);
          end
          cnt = 0;
          hic = 0;
        end
      end
    end
    en_prev = run_en;
    fp_prev = fp;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; run_en = 0; pre_sel = 0; swallow_a = 7'd5; main_b = 11'd6;
    repeat (3) @(negedge clk);
    check(fp == 1'b0, "R9", "fp in reset", int'(fp), 0);
    check(mod_hi == 1'b0, "R9", "mod_hi in reset", int'(mod_hi), 0);
    @(posedge clk); #1 rst_n = 1;

    // R1 / R2 / R3: P = 64, A = 5, B = 6, N = 389.
    drive_cfg(5, 6, 0);
    push_periods(5, 6, 0, 3, 1, "R1");
    @(posedge clk); #1 run_en = 1;

    // R4: A = 0 with P = 32, changed in mid-period (R7 on the period in flight).
    wait_left(1);
    repeat (7) @(posedge clk);
    drive_cfg(0, 3, 1);
    push_periods(0, 3, 1, 3, 1, "R4");

    // R5: A = B = 3 with P = 32, N = 99.
    wait_left(1);
    repeat (11) @(posedge clk);
    drive_cfg(3, 3, 1);
    push_periods(3, 3, 1, 3, 1, "R5");

    // R2: back to P = 64 with A = B = 63, N = 4095.
    wait_left(1);
    repeat (20) @(posedge clk);
    drive_cfg(63, 63, 0);
    push_periods(63, 63, 0, 2, 1, "R2");

    // R10: full-width B = 2047, A = 63, P = 32, N = 65567.
    wait_left(1);
    repeat (5) @(posedge clk);
    drive_cfg(63, 2047, 1);
    push_periods(63, 2047, 1, 1, 0, "R10");
    wait_left(0);

    // R8: stop in mid-period, stay idle, then restart with a full period.
    repeat (50) @(posedge clk);
    #1 run_en = 0;
    repeat (300) @(negedge clk);
    check(idle_pulses == 0, "R8", "pulses while idle", idle_pulses, 0);
    drive_cfg(2, 4, 1);
    push_periods(2, 4, 1, 2, 0, "R8");
    @(posedge clk); #1 run_en = 1;
    wait_left(0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule